// File: doc/BRIEF.md
# Two-Port Shared Memory with Collision Arbitration

This block is a 2048 x 8 shared memory that two agents reach through two independent ports, left and right. Each port has its own chip select, write enable, 11-bit address, write data, read data, read-valid flag and active-low busy flag. Accesses to different words go ahead in parallel on both ports with no interaction.

When both ports are selected on the same word in the same cycle, only one of them gets the word. The port that has held that word since an earlier cycle wins. If both arrive in the same cycle, left wins. The losing port sees its busy flag go low. Its write is dropped. Its read still returns the stored word, but with read-valid low. An agent that sees busy low after an access must treat that access as failed and issue it again.

All accesses are synchronous. Inputs are sampled on the rising clock edge. Read data, read-valid and busy are registered, so they describe the access made in the cycle just before.

Top module: `dpram_arb`

## Requirements
- R1: Under reset, both busy outputs are high (1 = not busy) and both read-valid outputs are low.
- R2: A selected read (cs=1, we=0) that does not lose returns the word at its address on read data in the following cycle, with read-valid high. A word written by one port can be read back by the other.
- R3: Two selected ports on different addresses both complete in the same cycle, and neither busy output goes low.
- R4: When both ports start accessing the same address in the same cycle, left wins. After the edge, right busy is low and left busy is high. The two busy outputs are never low together.
- R5: When one port has been selected on an address since the previous cycle and the other port arrives on it, the earlier port wins. This holds whichever side arrives first.
- R6: The winner keeps priority on every following cycle for as long as it stays selected on the same address.
- R7: A write from a losing port leaves the memory unchanged.
- R8: A read from a losing port still returns the stored word, but read-valid is low.
- R9: Busy returns high in the cycle after the winner drops chip select or moves to another address.
- R10: A port that was not selected in the previous cycle shows busy high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_cs_i | input | 1 | Left chip select |
| l_we_i | input | 1 | Left write enable (1 = write) |
| l_addr_i | input | 11 | Left word address |
| l_wdata_i | input | 8 | Left write data |
| l_rdata_o | output | 8 | Left read data, one cycle after the access |
| l_rvalid_o | output | 1 | Left read completed without contention |
| l_busy_no | output | 1 | Left lost arbitration in the last access (active low) |
| r_cs_i | input | 1 | Right chip select |
| r_we_i | input | 1 | Right write enable (1 = write) |
| r_addr_i | input | 11 | Right word address |
| r_wdata_i | input | 8 | Right write data |
| r_rdata_o | output | 8 | Right read data, one cycle after the access |
| r_rvalid_o | output | 1 | Right read completed without contention |
| r_busy_no | output | 1 | Right lost arbitration in the last access (active low) |

## Verification
The assertions assume that chip select, write enable and address are at known values on every edge after reset is released. They also assume that who arrived first can be told only from the previous cycle's select and address. The bench drives every input from reset onward. It changes inputs only well after an edge and keeps all ports deselected while reset is low. Scenarios that depend on order hold a port on one address for at least one whole cycle before the other port arrives, so each contention case comes from a known history.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpram_arb_ctl.sv
module dpram_arb_ctl
  import dpram_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_cs_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_lose_o,
  output logic              r_lose_o
);
  logic              l_cs_q, r_cs_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  owner_e            owner_q, owner_d;
  logic              clash, l_cont, r_cont;

  assign clash  = l_cs_i && r_cs_i && (l_addr_i == r_addr_i);
  // a port that sat on the same word last cycle arrived earlier
  assign l_cont = l_cs_i && l_cs_q && (l_addr_i == l_addr_q);
  assign r_cont = r_cs_i && r_cs_q && (r_addr_i == r_addr_q);

  always_comb begin
    owner_d = OWN_NONE;
    if (clash) begin
      if (l_cont && !r_cont)      owner_d = OWN_LEFT;
      else if (r_cont && !l_cont) owner_d = OWN_RIGHT;
      else if (l_cont && r_cont)  owner_d = (owner_q == OWN_RIGHT) ? OWN_RIGHT : OWN_LEFT;
      else                        owner_d = OWN_LEFT;  // same-cycle tie
    end
  end

  assign l_lose_o = (owner_d == OWN_RIGHT);
  assign r_lose_o = (owner_d == OWN_LEFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_cs_q   <= 1'b0;
      r_cs_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      owner_q  <= OWN_NONE;
    end else begin
      l_cs_q   <= l_cs_i;
      r_cs_q   <= r_cs_i;
      l_addr_q <= l_addr_i;
      r_addr_q <= r_addr_i;
      owner_q  <= owner_d;
    end
  end
endmodule

// File: rtl/dpram_arb_port.sv
module dpram_arb_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic we_i,
  input  logic lose_i,
  output logic wr_en_o,
  output logic rvalid_o,
  output logic busy_no
);
  assign wr_en_o = cs_i && we_i && !lose_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      busy_no  <= 1'b1;
    end else begin
      rvalid_o <= cs_i && !we_i && !lose_i;
      busy_no  <= !(cs_i && lose_i);
    end
  end
endmodule

// File: rtl/dpram_arb_mem.sv
module dpram_arb_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_cs_i,
  input  logic              a_wen_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_cs_i,
  input  logic              b_wen_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // arbiter guarantees both enables never target one word
  always_ff @(posedge clk_i) begin
    if (a_wen_i) mem_q[a_addr_i] <= a_wdata_i;
    if (b_wen_i) mem_q[b_addr_i] <= b_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_cs_i && !a_wen_i) a_rdata_o <= mem_q[a_addr_i];
      if (b_cs_i && !b_wen_i) b_rdata_o <= mem_q[b_addr_i];
    end
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_rvalid_o,
  output logic              l_busy_no,
  input  logic              r_cs_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_rvalid_o,
  output logic              r_busy_no
);
  logic l_lose, r_lose, l_wen, r_wen;

  dpram_arb_ctl #(.ADDR_W(ADDR_W)) i_ctl (
    .clk_i, .rst_ni,
    .l_cs_i, .l_addr_i, .r_cs_i, .r_addr_i,
    .l_lose_o(l_lose), .r_lose_o(r_lose)
  );

  dpram_arb_port i_lport (
    .clk_i, .rst_ni, .cs_i(l_cs_i), .we_i(l_we_i), .lose_i(l_lose),
    .wr_en_o(l_wen), .rvalid_o(l_rvalid_o), .busy_no(l_busy_no)
  );

  dpram_arb_port i_rport (
    .clk_i, .rst_ni, .cs_i(r_cs_i), .we_i(r_we_i), .lose_i(r_lose),
    .wr_en_o(r_wen), .rvalid_o(r_rvalid_o), .busy_no(r_busy_no)
  );

  dpram_arb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i, .rst_ni,
    .a_cs_i(l_cs_i), .a_wen_i(l_wen), .a_addr_i(l_addr_i),
    .a_wdata_i(l_wdata_i), .a_rdata_o(l_rdata_o),
    .b_cs_i(r_cs_i), .b_wen_i(r_wen), .b_addr_i(r_addr_i),
    .b_wdata_i(r_wdata_i), .b_rdata_o(r_rdata_o)
  );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_cs_i,
  input logic              l_we_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_rvalid_o,
  input logic              l_busy_no,
  input logic              r_cs_i,
  input logic              r_we_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_rvalid_o,
  input logic              r_busy_no
);
  logic              p_l_cs, p_r_cs;
  logic [ADDR_W-1:0] p_l_addr, p_r_addr;
  logic              same, l_old, r_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_l_cs <= 1'b0; p_r_cs <= 1'b0; p_l_addr <= '0; p_r_addr <= '0;
    end else begin
      p_l_cs <= l_cs_i; p_r_cs <= r_cs_i; p_l_addr <= l_addr_i; p_r_addr <= r_addr_i;
    end
  end

  assign same  = l_cs_i && r_cs_i && (l_addr_i == r_addr_i);
  assign l_old = p_l_cs && (p_l_addr == l_addr_i);
  assign r_old = p_r_cs && (p_r_addr == r_addr_i);

  AST_IDLE_L_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_cs_i |=> l_busy_no);  // R10
  AST_IDLE_R_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_cs_i |=> r_busy_no);  // R10
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_busy_no || r_busy_no);  // R4
  AST_DIFF_ADDR_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_cs_i && r_cs_i && l_addr_i != r_addr_i) |=> (l_busy_no && r_busy_no));  // R3
  AST_TIE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same && !l_old && !r_old) |=> (l_busy_no && !r_busy_no));  // R4
  AST_EARLY_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same && l_old && !r_old) |=> (l_busy_no && !r_busy_no));  // R5
  AST_EARLY_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same && r_old && !l_old) |=> (r_busy_no && !l_busy_no));  // R5
  AST_LOSER_L_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_busy_no |-> !l_rvalid_o);  // R8
  AST_LOSER_R_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_busy_no |-> !r_rvalid_o);  // R8
  AST_READ_L_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_cs_i && !l_we_i && !same) |=> l_rvalid_o);  // R2
  AST_READ_R_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_cs_i && !r_we_i && !same) |=> r_rvalid_o);  // R2
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_cs_i(l_cs_i), .l_we_i(l_we_i), .l_addr_i(l_addr_i),
  .l_rvalid_o(l_rvalid_o), .l_busy_no(l_busy_no),
  .r_cs_i(r_cs_i), .r_we_i(r_we_i), .r_addr_i(r_addr_i),
  .r_rvalid_o(r_rvalid_o), .r_busy_no(r_busy_no)
);

// File: tb/test_dpram_arb.sv
module test_dpram_arb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        l_cs_i = 0, l_we_i = 0, r_cs_i = 0, r_we_i = 0;
  logic [10:0] l_addr_i = '0, r_addr_i = '0;
  logic [7:0]  l_wdata_i = '0, r_wdata_i = '0;
  logic [7:0]  l_rdata_o, r_rdata_o;
  logic        l_rvalid_o, r_rvalid_o, l_busy_no, r_busy_no;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2.5 clk_i = ~clk_i;

  dpram_arb i_dpram_arb (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic lset(input logic cs, input logic we, input int a, input int d);
    l_cs_i = cs; l_we_i = we; l_addr_i = 11'(a); l_wdata_i = 8'(d);
  endtask

  task automatic rset(input logic cs, input logic we, input int a, input int d);
    r_cs_i = cs; r_we_i = we; r_addr_i = 11'(a); r_wdata_i = 8'(d);
  endtask

  task automatic idle();
    lset(0, 0, 0, 0); rset(0, 0, 0, 0); step();
  endtask

  task automatic t_reset();
    chk("R1 l_busy", l_busy_no, 1); chk("R1 r_busy", r_busy_no, 1);
    chk("R1 l_rvalid", l_rvalid_o, 0); chk("R1 r_rvalid", r_rvalid_o, 0);
  endtask

  task automatic t_basic();
    lset(1, 1, 10, 8'h5a); step();
    lset(0, 0, 0, 0); rset(1, 0, 10, 0); step();
    chk("R2 r_rdata", r_rdata_o, 8'h5a); chk("R2 r_rvalid", r_rvalid_o, 1);
    rset(1, 1, 20, 8'hc3); step();
    rset(0, 0, 0, 0); lset(1, 0, 20, 0); step();
    chk("R2 l_rdata", l_rdata_o, 8'hc3); chk("R2 l_rvalid", l_rvalid_o, 1);
    idle();
  endtask

  task automatic t_parallel();
    lset(1, 1, 30, 8'h11); rset(1, 1, 31, 8'h22); step();
    chk("R3 l_busy", l_busy_no, 1); chk("R3 r_busy", r_busy_no, 1);
    lset(1, 0, 31, 0); rset(1, 0, 30, 0); step();
    chk("R3 l_rdata", l_rdata_o, 8'h22); chk("R3 r_rdata", r_rdata_o, 8'h11);
    chk("R3 both valid", {l_rvalid_o, r_rvalid_o}, 2'b11);
    idle();
  endtask

  task automatic t_tie();
    lset(1, 1, 40, 8'haa); rset(1, 1, 40, 8'hbb); step();
    chk("R4 l_busy", l_busy_no, 1); chk("R4 r_busy", r_busy_no, 0);
    lset(0, 0, 0, 0); rset(0, 0, 0, 0); step();
    chk("R10 l_busy idle", l_busy_no, 1); chk("R10 r_busy idle", r_busy_no, 1);
    rset(1, 0, 40, 0); step();
    chk("R7 tie word", r_rdata_o, 8'haa);
    idle();
  endtask

  task automatic t_order();
    rset(1, 1, 50, 8'h77); step();
    rset(1, 0, 50, 0); step();  // right now holds word 50
    lset(1, 1, 50, 8'h99); step();
    chk("R5 l_busy", l_busy_no, 0); chk("R5 r_busy", r_busy_no, 1);
    chk("R5 r_rvalid", r_rvalid_o, 1);
    step();
    chk("R6 l_busy held", l_busy_no, 0); chk("R7 word kept", r_rdata_o, 8'h77);
    rset(0, 0, 0, 0); step();
    chk("R9 l_busy release", l_busy_no, 1);
    lset(0, 0, 0, 0); rset(1, 0, 50, 0); step();
    chk("R9 write after release", r_rdata_o, 8'h99);
    idle();
  endtask

  task automatic t_loser_read();
    lset(1, 1, 60, 8'h3c); step();
    lset(1, 0, 60, 0); step();
    rset(1, 0, 60, 0); step();
    chk("R8 r_busy", r_busy_no, 0); chk("R8 r_rvalid", r_rvalid_o, 0);
    chk("R8 r_rdata", r_rdata_o, 8'h3c); chk("R5 l_rvalid", l_rvalid_o, 1);
    lset(1, 0, 61, 0); step();
    chk("R9 r_busy move", r_busy_no, 1); chk("R9 r_rvalid", r_rvalid_o, 1);
    idle();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_basic();
    t_parallel();
    t_tie();
    t_order();
    t_loser_read();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule